// File: doc/BRIEF.md
# Echo Buffer Clear Engine

This block erases the echo delay buffer that an audio signal processor keeps in a shared 64 KiB RAM. A controller pulses `start` while presenting three processor register values: a flag byte, a base page and a length code. If the flag byte says echo writes are allowed, the engine writes the byte 0xFF to every location of the buffer, one byte per clock, through a simple RAM write port. If echo writes are not allowed, it writes nothing and reports completion at once.

The buffer begins at the base page times 256. Its length is the length code times 2048 bytes. A buffer that would run past the last RAM address is cut short at address 0xFFFF. The fill never wraps back to address zero. `busy` covers the write burst, and `done` marks its end with a one-cycle pulse. Bus arbitration is outside this block.

The controller is a three-state machine. **IDLE** waits for `start`. On a start with a non-empty, enabled fill, the **IDLE→FILL** transition is taken. When the fill is disabled or the length code is zero, the **IDLE→DONE** transition is taken instead. **FILL** issues one write per cycle and takes **FILL→DONE** on its last write. **DONE** lasts exactly one cycle and then takes **DONE→IDLE**.

Top module: `echo_clear_engine`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `wr_en` are all low.
- R2: A `start` sampled high in IDLE captures `cfg_flag`, `cfg_page` and `cfg_len` at that clock edge. For an enabled, non-empty fill, `busy` and the first write appear in the next cycle.
- R3: The first write goes to address `cfg_page` × 256.
- R4: Writes go to consecutive increasing addresses, one per cycle with no gaps, and number `cfg_len` × 2048 when no clamp applies.
- R5: `wr_en` is high exactly while `busy` is high, and every written byte is 0xFF.
- R6: The number of writes is the smaller of `cfg_len` × 2048 and 65536 − `cfg_page` × 256. The last write is never above 0xFFFF, and the address never wraps to 0.
- R7: When bit 5 of `cfg_flag` is 1 at start, the engine makes no write, and `done` is high in the cycle after the start edge.
- R8: When `cfg_len` is 0 at start, the engine makes no write, and `done` is high in the cycle after the start edge.
- R9: `done` is high for exactly one cycle, in the cycle right after the last write, with `busy` low. `busy` and `done` are never high together.
- R10: A `start` pulse while `busy` or `done` is high is ignored. Changes to the configuration inputs during a fill do not change its addresses or length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in IDLE |
| cfg_flag | input | 8 | Flag byte; bit 5 set disables the fill |
| cfg_page | input | 8 | Buffer base page (address = value × 256) |
| cfg_len | input | 8 | Length code (bytes = value × 2048) |
| busy | output | 1 | High while fill writes are issued |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 16 | RAM write address |
| wr_data | output | 8 | RAM write data (0xFF during writes) |

## Verification
The hardest case to reach is the clamp at the top of memory, and in particular the case where the requested length exactly equals the room left. That case needs a high base page paired with a length code large enough to reach the top, and random values seldom produce such a pair. The stimulus therefore adds directed pairs for three situations: the clamp cutting the fill to a single page, the exact-fit case, and a start one page below the top. It also injects a stray start with changed configuration in the middle of a long fill. This confirms that neither the burst nor its addresses move.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } ecl_state_e;
endpackage

// File: rtl/ecl_span_calc.sv
// Turns the captured register codes into a base address, a clamped byte count
// and a skip decision.
module ecl_span_calc #(
    parameter int ADDR_W     = 16,
    parameter int REG_W      = 8,
    parameter int PAGE_SHIFT = 8,
    parameter int LEN_SHIFT  = 11,
    parameter int SKIP_BIT   = 5
) (
    input  logic [REG_W-1:0]  flag_i,
    input  logic [REG_W-1:0]  page_i,
    input  logic [REG_W-1:0]  len_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W:0]   count_o,
    output logic              skip_o
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int REQ_W = REG_W + LEN_SHIFT;
    localparam int CMP_W = (REQ_W > CNT_W) ? REQ_W : CNT_W;

    logic [CMP_W-1:0] room_w;
    logic [CMP_W-1:0] req_w;

    always_comb begin
        base_o  = ADDR_W'({page_i, {PAGE_SHIFT{1'b0}}});
        room_w  = (CMP_W'(1) << ADDR_W) - CMP_W'(base_o);
        req_w   = CMP_W'({len_i, {LEN_SHIFT{1'b0}}});
        count_o = (req_w < room_w) ? CNT_W'(req_w) : CNT_W'(room_w);
        skip_o  = flag_i[SKIP_BIT] | (len_i == '0);
    end
endmodule

// File: rtl/ecl_addr_gen.sv
// Address counter with a remaining-bytes counter; flags the final write.
module ecl_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   count_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int CNT_W = ADDR_W + 1;

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            rem_q  <= '0;
        end else if (load_i) begin
            addr_o <= base_i;
            rem_q  <= count_i;
        end else if (step_i) begin
            addr_o <= addr_o + ADDR_W'(1);
            rem_q  <= rem_q - CNT_W'(1);
        end
    end

    assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/echo_clear_engine.sv
module echo_clear_engine #(
    parameter int ADDR_W     = 16,
    parameter int REG_W      = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_SHIFT = 8,
    parameter int LEN_SHIFT  = 11,
    parameter int SKIP_BIT   = 5,
    parameter logic [DATA_W-1:0] FILL_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  cfg_flag,
    input  logic [REG_W-1:0]  cfg_page,
    input  logic [REG_W-1:0]  cfg_len,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    import ecl_pkg::*;

    ecl_state_e       state_q, state_d;
    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W:0]   count_w;
    logic              skip_w;
    logic              load_w;
    logic              step_w;
    logic              last_w;

    ecl_span_calc #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .PAGE_SHIFT(PAGE_SHIFT),
        .LEN_SHIFT(LEN_SHIFT), .SKIP_BIT(SKIP_BIT)
    ) u_span (
        .flag_i(cfg_flag), .page_i(cfg_page), .len_i(cfg_len),
        .base_o(base_w), .count_o(count_w), .skip_o(skip_w)
    );

    ecl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .base_i(base_w), .count_i(count_w), .addr_o(wr_addr), .last_o(last_w)
    );

    assign load_w = (state_q == ST_IDLE) && start;
    assign step_w = (state_q == ST_FILL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = skip_w ? ST_DONE : ST_FILL;
            ST_FILL: if (last_w) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: begin
                busy    = 1'b1;
                wr_en   = 1'b1;
                wr_data = FILL_VAL;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
    parameter int ADDR_W   = 16,
    parameter int REG_W    = 8,
    parameter int DATA_W   = 8,
    parameter int SKIP_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [REG_W-1:0]  cfg_flag,
    input logic [REG_W-1:0]  cfg_page,
    input logic [REG_W-1:0]  cfg_len,
    input logic              busy,
    input logic              done,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    logic idle_w;
    assign idle_w = !busy && !done;

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!busy && !done && !wr_en);
        end
    end

    assert_first_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_w && !cfg_flag[SKIP_BIT] && cfg_len != '0)
        |=> (wr_en && wr_addr == ADDR_W'({$past(cfg_page), 8'h00})));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == busy);

    assert_fill_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == DATA_W'(8'hFF)));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr != '0));

    assert_skip_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_w && cfg_flag[SKIP_BIT]) |=> (done && !wr_en));

    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_w && cfg_len == '0) |=> (done && !wr_en));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind echo_clear_engine ecl_checker #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .SKIP_BIT(SKIP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_flag(cfg_flag),
    .cfg_page(cfg_page), .cfg_len(cfg_len), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_echo_clear_engine.sv
`timescale 1ns/1ps
module sim_echo_clear_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_flag = '0;
    logic [7:0]  cfg_page = '0;
    logic [7:0]  cfg_len = '0;
    logic        busy, done, wr_en;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    echo_clear_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_flag(cfg_flag),
        .cfg_page(cfg_page), .cfg_len(cfg_len), .busy(busy), .done(done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic int exp_count(input logic [7:0] f, input logic [7:0] p, input logic [7:0] l);
        int req, room;
        if (f[5] || l == 8'd0) return 0;
        req  = int'(l) * 2048;
        room = 65536 - int'(p) * 256;
        return (req < room) ? req : room;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] f, input logic [7:0] p,
                            input logic [7:0] l, input bit stray);
        int exp_n, n, k;
        bit seen_done, addr_ok, data_ok;
        exp_n = exp_count(f, p, l);
        @(negedge clk);
        cfg_flag = f; cfg_page = p; cfg_len = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; k = 0; seen_done = 0; addr_ok = 1; data_ok = 1;
        while (!seen_done && k <= exp_n + 2) begin
            if (wr_en) begin
                if (wr_addr != 16'((int'(p) * 256 + n) & 16'hFFFF)) addr_ok = 0;
                if (wr_data != 8'hFF || !busy) data_ok = 0;
                n++;
            end
            if (done) begin
                seen_done = 1;
                // R7 R8 R9: done arrives in the cycle right after the last write
                chk(k == exp_n && !busy, "R9 done timing", k, exp_n);
            end else begin
                if (stray && k == 3) begin
                    start = 1'b1; cfg_page = p ^ 8'h40; cfg_len = 8'd1; cfg_flag = 8'h20;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                k++;
            end
        end
        start = 1'b0;
        chk(seen_done, "R9 done seen", seen_done, 1);
        chk(addr_ok, "R3 R4 addresses", addr_ok, 1);
        chk(data_ok, "R5 data and busy", data_ok, 1);
        chk(n == exp_n, (f[5] ? "R7 count" : (l == 0 ? "R8 count" : "R6 count")), n, exp_n);
        if (stray) chk(n == exp_n, "R10 stray start", n, exp_n);
        @(negedge clk);
        chk(!done && !busy && !wr_en, "R9 single pulse", done, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1 reset", {busy, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3: first write the cycle after start, at page*256
        run_case(8'h00, 8'h12, 8'd1, 1'b0);
        run_case(8'h20, 8'h10, 8'd4, 1'b0);   // R7 flag set
        run_case(8'hFF, 8'h00, 8'd9, 1'b0);   // R7 all flag bits
        run_case(8'h00, 8'h30, 8'd0, 1'b0);   // R8 zero length
        run_case(8'h00, 8'hFC, 8'd1, 1'b0);   // R6 clamp to 1 KiB
        run_case(8'h00, 8'hFF, 8'd255, 1'b0); // R6 clamp to one page
        run_case(8'h00, 8'hF0, 8'd2, 1'b0);   // R6 exact fit
        run_case(8'hDF, 8'h20, 8'd3, 1'b1);   // R10 stray start mid fill
        for (int i = 0; i < 10; i++) begin
            logic [7:0] rf, rp, rl;
            rf = 8'($urandom) & ((($urandom % 4) == 0) ? 8'hFF : 8'hDF);
            rp = 8'($urandom);
            rl = 8'($urandom % 5);
            run_case(rf, rp, rl, ($urandom % 2) == 1); // R4 R6 random
        end
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) chk(1'b0, "watchdog", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule